// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the frequency-offset word that steers a fractional-N feedback divider or a digitally controlled oscillator, so that a synthesized clock is swept symmetrically around the reference frequency. Spreading the clock's energy this way lowers the peak amplitude of its harmonics. The block runs from the reference clock. One full sweep takes a fixed number of reference cycles, so the modulation rate scales with the reference frequency. The supported reference range is 25 to 60 MHz.

The sweep is a triangle. It starts at zero, climbs to the positive peak, falls through zero to the negative peak and climbs back to zero. Each of the four quarter-ramps lasts `QTR_LEN` cycles, with a default of 288, which gives a 1152-cycle period. The offset is a signed word in units of 0.01 %. A 2-bit range select chooses the peak, and an active-low enable gates the sweep. Both inputs pass through two-flop synchronizers. They are taken into account only at the start of a period, where the offset is zero, so the output never jumps. An update strobe is high in every cycle in which the offset was advanced.

Top module: `ssm_profile_gen`

## Requirements
- R1: The peak deviation follows the synchronized `range_sel` latched at the start of a period: 2'b10 gives ±50, 2'b11 gives ±100, 2'b00 gives ±150 and 2'b01 gives ±250 (units of 0.01 %).
- R2: In one period, `offset_o` after the k-th update, with p = k mod 4·QTR_LEN and Q = QTR_LEN, equals floor(P·p/Q) for p ≤ Q, floor(P·(2Q−p)/Q) for Q < p ≤ 2Q, −floor(P·(p−2Q)/Q) for 2Q < p ≤ 3Q and −floor(P·(4Q−p)/Q) otherwise. The positive and negative excursions are therefore mirror images.
- R3: One period is 4·QTR_LEN = 1152 updates. The offset is +P after 288 updates, −P after 864 updates and 0 after 1152 updates.
- R4: While the sweep is stopped, `offset_o` is 0 and `upd_o` is 0. Changing `range_sel` while stopped has no effect on either output.
- R5: With `range_sel` = 2'b11 and `spread_en_n` = 0, which are the default levels of the pulled inputs, the sweep peaks at ±100.
- R6: A change of `range_sel` in mid-period does not alter the current period. The new peak applies from the next period, which follows without a gap.
- R7: When `spread_en_n` rises in mid-period, the sweep completes the period back to zero and then holds at zero.
- R8: `offset_o` changes by at most one unit between consecutive cycles.
- R9: The synchronous active-low reset clears the phase, the offset and the strobe to zero in the cycle after the clock edge that samples it.
- R10: `upd_o` is 1 in every cycle of a running sweep, including the cycle in which the period wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| range_sel | input | 2 | Spreading range select (asynchronous) |
| spread_en_n | input | 1 | Spread enable, active low (asynchronous) |
| offset_o | output | OFS_W (12) | Signed frequency offset in units of 0.01 % |
| upd_o | output | 1 | High in each cycle in which the offset was advanced |

## Verification
Every range code is run through a full period with the enable held low. The whole 1152-point trace is compared with the arithmetic floor formula, which separates a wrong peak value from a wrong slope, a wrong quarter boundary or an asymmetric negative half. A range code is changed at update 300 of a running period. This distinguishes mid-period sampling, which breaks the trace, from sampling only at the zero crossing, which takes effect in the following period. The enable is deasserted at update 600. The trace must then run to zero and stay there, which separates an abrupt stop from a completed period. Range changes while stopped and a reset in mid-sweep test that the held outputs really stay at zero.

// File: rtl/ssm_pkg.sv
// Shared definitions for the spread-spectrum profile generator.
// Holds the range-select codes and the peak deviation of each code,
// expressed in units of 0.01 %.
package ssm_pkg;

    localparam int PEAK_W = 8;

    typedef enum logic [1:0] {
        RNG_W150 = 2'b00,
        RNG_W250 = 2'b01,
        RNG_W050 = 2'b10,
        RNG_W100 = 2'b11
    } range_e;

    // Peak deviation for a select code; every peak must stay below QTR_LEN.
    function automatic logic [PEAK_W-1:0] peak_of(input logic [1:0] sel);
        case (range_e'(sel))
            RNG_W150: peak_of = PEAK_W'(150);
            RNG_W250: peak_of = PEAK_W'(250);
            RNG_W050: peak_of = PEAK_W'(50);
            default:  peak_of = PEAK_W'(100);
        endcase
    endfunction

endpackage

// File: rtl/ssm_sync.sv
// Two-flop synchronizer for slowly changing mode inputs.
// Assumes each bit is quasi-static, so per-bit skew between bits is
// harmless: the mode is only used at the start of a period.
module ssm_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/ssm_phase.sv
// Phase sequencer: counts 0 .. 4*QTR_LEN-1 while the sweep runs.
// The mode (run/stop and peak) is taken from the synchronized inputs
// only when the phase is zero, that is, at the start of a period.
// A period that has been started is always completed.
module ssm_phase
    import ssm_pkg::*;
#(
    parameter int QTR_LEN = 288,
    localparam int PERIOD = 4 * QTR_LEN,
    localparam int PH_W   = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_s,
    input  logic [1:0]        sel_s,
    output logic [PH_W-1:0]   ph_o,
    output logic              run_o,
    output logic [PEAK_W-1:0] peak_o
);
    logic [PH_W-1:0]   ph_q;
    logic              active_q;
    logic [PEAK_W-1:0] peak_q;
    logic              at_zero;

    // Mode is re-sampled only at the zero crossing that opens a period
    always_comb begin
        at_zero = (ph_q == '0);
        run_o   = at_zero ? ~en_n_s : active_q;
        peak_o  = at_zero ? peak_of(sel_s) : peak_q;
    end

    // Advance the phase and hold the mode latched for the period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            active_q <= 1'b0;
            peak_q   <= '0;
        end else begin
            active_q <= run_o;
            peak_q   <= peak_o;
            if (run_o)
                ph_q <= (ph_q == PH_W'(PERIOD - 1)) ? '0 : PH_W'(ph_q + 1'b1);
        end
    end

    assign ph_o = ph_q;

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PH_W'(PERIOD - 1));

    // R7
    idle_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (ph_q == '0));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != '0) |=> (peak_q == $past(peak_q)));
endmodule

// File: rtl/ssm_ramp.sv
// Triangle magnitude generator without a multiplier.
// A running remainder in units of 1/QTR_LEN makes the magnitude equal to
// floor(peak * k / QTR_LEN), where k is the distance from the nearest
// zero crossing. The magnitude moves up or down by at most one per cycle.
// Assumes peak < QTR_LEN, so at most one carry or borrow happens per step.
module ssm_ramp
    import ssm_pkg::*;
#(
    parameter int QTR_LEN = 288,
    parameter int OFS_W   = 12,
    localparam int PERIOD = 4 * QTR_LEN,
    localparam int PH_W   = $clog2(PERIOD),
    localparam int REM_W  = $clog2(QTR_LEN) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic [PH_W-1:0]         ph_i,
    input  logic [PEAK_W-1:0]       peak_i,
    output logic signed [OFS_W-1:0] offset_o
);
    localparam logic [REM_W-1:0] QV = REM_W'(QTR_LEN);

    logic [REM_W-1:0]  rem_q, rem_nx, sum_up, pk_w;
    logic [PEAK_W-1:0] mag_q, mag_nx;
    logic              neg_q, neg_nx, rising;
    logic signed [OFS_W-1:0] mag_s;

    // Direction and sign of the next step from the current phase
    always_comb begin
        rising = (ph_i < PH_W'(QTR_LEN)) ||
                 ((ph_i >= PH_W'(2 * QTR_LEN)) && (ph_i < PH_W'(3 * QTR_LEN)));
        neg_nx = (ph_i >= PH_W'(2 * QTR_LEN)) && (ph_i <= PH_W'(PERIOD - 2));
    end

    // Remainder carry on the way up, borrow on the way down
    always_comb begin
        pk_w   = REM_W'(peak_i);
        sum_up = rem_q + pk_w;
        rem_nx = rem_q;
        mag_nx = mag_q;
        if (rising) begin
            if (sum_up >= QV) begin
                rem_nx = sum_up - QV;
                mag_nx = mag_q + 1'b1;
            end else begin
                rem_nx = sum_up;
            end
        end else begin
            if (rem_q >= pk_w) begin
                rem_nx = rem_q - pk_w;
            end else begin
                rem_nx = rem_q + QV - pk_w;
                mag_nx = mag_q - 1'b1;
            end
        end
    end

    // Register the magnitude, remainder and sign on each running cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            mag_q <= '0;
            neg_q <= 1'b0;
        end else if (run_i) begin
            rem_q <= rem_nx;
            mag_q <= mag_nx;
            neg_q <= neg_nx;
        end
    end

    // Apply the sign to form the signed offset
    always_comb begin
        mag_s    = OFS_W'(mag_q);
        offset_o = neg_q ? -mag_s : mag_s;
    end

    // R2
    zero_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_i == '0) || (ph_i == PH_W'(2 * QTR_LEN))) |-> ((mag_q == '0) && (rem_q == '0)));

    // R3
    crest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_i == PH_W'(QTR_LEN)) || (ph_i == PH_W'(3 * QTR_LEN))) |-> (mag_q == peak_i));
endmodule

// File: rtl/ssm_profile_gen.sv
// Spread-spectrum modulation profile generator (top level).
// Synchronizes the range select and the active-low enable, sequences a
// triangular sweep of 4*QTR_LEN reference cycles and outputs a signed
// offset in units of 0.01 %, together with a per-update strobe.
// Assumes every peak in the range table is below QTR_LEN.
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int QTR_LEN = 288,
    parameter int OFS_W   = 12,
    localparam int PERIOD = 4 * QTR_LEN,
    localparam int PH_W   = $clog2(PERIOD)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              range_sel,
    input  logic                    spread_en_n,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    upd_o
);
    localparam logic signed [OFS_W-1:0] STEP_P = OFS_W'(1);
    localparam logic signed [OFS_W-1:0] STEP_N = -STEP_P;

    logic [1:0]        sel_s;
    logic [0:0]        en_n_s;
    logic [PH_W-1:0]   ph;
    logic              run;
    logic [PEAK_W-1:0] peak;
    logic              upd_q;

    ssm_sync #(.W(2), .RST_VAL(2'b11)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d_i(range_sel), .q_o(sel_s)
    );

    ssm_sync #(.W(1), .RST_VAL(1'b1)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d_i(spread_en_n), .q_o(en_n_s)
    );

    ssm_phase #(.QTR_LEN(QTR_LEN)) u_phase (
        .clk(clk), .rst_n(rst_n), .en_n_s(en_n_s[0]), .sel_s(sel_s),
        .ph_o(ph), .run_o(run), .peak_o(peak)
    );

    ssm_ramp #(.QTR_LEN(QTR_LEN), .OFS_W(OFS_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .run_i(run), .ph_i(ph), .peak_i(peak),
        .offset_o(offset_o)
    );

    // Strobe marks each cycle in which the offset was advanced
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= run;
    end

    assign upd_o = upd_q;

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> (offset_o == '0));

    // R8
    slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((offset_o - $past(offset_o)) == '0) ||
                  ((offset_o - $past(offset_o)) == STEP_P) ||
                  ((offset_o - $past(offset_o)) == STEP_N)));
endmodule

// File: tb/tb_ssm_profile_gen.sv
// Bench for the profile generator: full-period trace comparison for every
// range code against the arithmetic floor model, plus mode-change,
// disable-in-mid-period and reset cases.
module tb_ssm_profile_gen;
    localparam int Q   = 288;
    localparam int PER = 4 * Q;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] range_sel = 2'b11;   // pulled-up default
    logic spread_en_n = 1'b0;        // pulled-down default
    logic signed [11:0] offset_o;
    logic upd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ssm_profile_gen dut (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel),
        .spread_en_n(spread_en_n), .offset_o(offset_o), .upd_o(upd_o)
    );

    always #2 clk = ~clk;

    function automatic int exp_off(input int pk, input int p);
        if (p <= Q)          return (pk * p) / Q;
        else if (p <= 2 * Q) return (pk * (2 * Q - p)) / Q;
        else if (p <= 3 * Q) return -((pk * (p - 2 * Q)) / Q);
        else                 return -((pk * (4 * Q - p)) / Q);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_start();
        int guard = 0;
        @(negedge clk);
        while (!upd_o && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        check(upd_o == 1'b1, "R10 start", int'(upd_o), 1);
    endtask

    // One period; the first sample is the current negedge when first_now is set
    task automatic run_period(input int pk, input bit first_now, input int cut_at,
                              input int sw_at, input logic [1:0] sw_sel, input string tag);
        int mism = 0;
        int mx = -1000;
        int mn = 1000;
        int upd_miss = 0;
        for (int i = 1; i <= PER; i++) begin
            if (i > 1 || !first_now) @(negedge clk);
            if (int'(offset_o) != exp_off(pk, i % PER)) begin
                if (mism == 0)
                    $display("FAIL %s R2 trace at update %0d: actual %0d expected %0d",
                             tag, i, int'(offset_o), exp_off(pk, i % PER));
                mism++;
            end
            if (!upd_o) upd_miss++;
            if (int'(offset_o) > mx) mx = int'(offset_o);
            if (int'(offset_o) < mn) mn = int'(offset_o);
            if (i == Q)     check(int'(offset_o) == pk,  "R3 crest at 288", int'(offset_o), pk);
            if (i == 3 * Q) check(int'(offset_o) == -pk, "R3 trough at 864", int'(offset_o), -pk);
            if (i == PER)   check(int'(offset_o) == 0,   "R3 zero at 1152", int'(offset_o), 0);
            if (i == cut_at) spread_en_n = 1'b1;
            if (i == sw_at)  range_sel = sw_sel;
        end
        n_chk++;
        if (mism != 0) n_fail++;
        check(mx == pk,  "R1 peak", mx, pk);
        check(mn == -pk, "R2 symmetric trough", mn, -pk);
        check(upd_miss == 0, "R10 strobe", upd_miss, 0);
    endtask

    task automatic check_held(input int cycles, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (upd_o || offset_o != 0) bad++;
            if (i == cycles / 2) range_sel = ~range_sel;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        spread_en_n = 1'b1;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(offset_o == 0 && upd_o == 0, "R9 reset", int'(offset_o), 0);
        rst_n = 1'b1;
        check_held(20, "R4 held while disabled");

        // R5 default pulls: select 11, enable low -> +/-100; R7 cut at 600
        range_sel = 2'b11;
        spread_en_n = 1'b0;
        wait_start();
        run_period(100, 1'b1, 600, 0, 2'b11, "R5 default");
        check_held(60, "R7 R4 zero after period completes");

        // R1 remaining codes
        range_sel = 2'b00; spread_en_n = 1'b0;
        wait_start();
        run_period(150, 1'b1, 600, 0, 2'b00, "R1 code00");
        check_held(40, "R7 stop code00");

        range_sel = 2'b01; spread_en_n = 1'b0;
        wait_start();
        run_period(250, 1'b1, 600, 0, 2'b01, "R1 code01");
        check_held(40, "R7 stop code01");

        range_sel = 2'b10; spread_en_n = 1'b0;
        wait_start();
        run_period(50, 1'b1, 600, 0, 2'b10, "R1 code10");
        check_held(40, "R7 stop code10");

        // R6 mid-period range change takes effect at the next period
        range_sel = 2'b11; spread_en_n = 1'b0;
        wait_start();
        run_period(100, 1'b1, 0, 300, 2'b01, "R6 old range");
        run_period(250, 1'b0, 600, 0, 2'b01, "R6 new range");
        check_held(40, "R7 stop after R6");

        // R9 reset in mid-sweep
        range_sel = 2'b00; spread_en_n = 1'b0;
        wait_start();
        repeat (400) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(offset_o == 0, "R9 mid-sweep reset offset", int'(offset_o), 0);
        check(upd_o == 0, "R9 mid-sweep reset strobe", int'(upd_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        spread_en_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule